// File: doc/BRIEF.md
# UART Status Flag Controller

This block holds the five status flags of a serial port and turns them into one interrupt request. The five flags are: transmit holding register free, transmission finished, received word waiting, line gone idle, and received word lost. Hardware events set the flags. The baud logic and the shift registers sit outside this block and report each event as a single-cycle strobe. Software clears the flags through a small register port with two registers: a status register and a data register.

Some flags clear on one access. Others need a two-step sequence: a status-register read, then the next data-register access. A one-bit tracker remembers that the status register was read. If any other access comes between the two steps, the sequence breaks. The received word goes into a one-word buffer, which software reads through the data register. A word written to the data register appears on a holding output for the transmitter.

The event strobes and the register port are plain control pins and carry no back-pressure. A word offered on the receive strobe is never refused. If the buffer is still full, the word is dropped and the lost-word flag records the loss.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset, the status register reads 0xC0 and `irq` is 0. The idle flag is also disarmed, so an idle strobe before the first received word leaves the status unchanged.
- R2: Status register layout (`reg_sel`=0): bit 7 tx-empty, bit 6 tx-done, bit 5 rx-full, bit 4 idle, bit 3 overrun, bits 2..0 read 0. With `reg_sel`=1, `rd_data` returns the buffered received word.
- R3: `tx_load` sets tx-empty. A data-register write (`reg_sel`=1, `wr_en`) clears tx-empty, and the written byte appears on `tx_hold_data` from the next cycle.
- R4: `tx_frame_done` sets tx-done only when tx-empty is 1 in that cycle. Otherwise it is ignored.
- R5: tx-done clears when a data-register write follows a status-register read with no other access between them. A status-register write with bit 6 = 0 also clears it. Writing 1 to bit 6 has no effect, and a status write between the two steps breaks the sequence.
- R6: `rx_valid` with rx-full at 0 stores `rx_word` in the buffer and sets rx-full. A data-register read clears rx-full, and so does a status write with bit 5 = 0.
- R7: `rx_valid` with rx-full at 1 and no data read in that cycle sets overrun. The buffer keeps its old word.
- R8: The idle and overrun flags clear only when a data-register read follows a status-register read with no other access between them. A data read on its own clears neither flag.
- R9: `idle_det` sets the idle flag only while armed. Storing a received word arms the idle flag, and setting the idle flag disarms it.
- R10: When a hardware set and a software clear of the same flag fall in one cycle, the set wins.
- R11: `irq` is registered. It goes high one cycle after any of these terms is true: (tx-empty & `ie_txe`), (tx-done & `ie_tc`), ((rx-full | overrun) & `ie_rxne`), (idle & `ie_idle`), or (overrun & `ie_err` & `multibuf`).
- R12: A data read in the same cycle as `rx_valid` while rx-full is 1 stores the new word, leaves rx-full at 1, and does not set overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 = status register, 1 = data register |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the selected register (combinational) |
| tx_load | input | 1 | Holding register moved into the transmit shifter |
| tx_frame_done | input | 1 | Data frame finished shifting out |
| tx_hold_data | output | DATA_W | Last byte written to the data register |
| rx_valid | input | 1 | Receive shifter has a complete word |
| rx_word | input | DATA_W | Word from the receive shifter |
| idle_det | input | 1 | Idle line detected |
| ie_txe | input | 1 | Interrupt enable for tx-empty |
| ie_tc | input | 1 | Interrupt enable for tx-done |
| ie_rxne | input | 1 | Interrupt enable for rx-full and overrun |
| ie_idle | input | 1 | Interrupt enable for idle |
| ie_err | input | 1 | Error enable for overrun in multibuffer mode |
| multibuf | input | 1 | Multibuffer mode select |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can land in the same cycle: a flag's hardware set and its software clear, and a data-register read and an incoming receive word. The bench provokes both on purpose. A frame-done strobe rides on the data write that ends the tx-done clear sequence. An idle strobe rides on the data read that ends the idle clear sequence. A receive word arrives in the same cycle as a data read while the buffer is full. In each case the bench expects the set-wins outcome and checks the buffer contents. A random phase then mixes every access and strobe, and the bench's own model judges the result on every clock.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int POS_TXE  = 7;
  localparam int POS_TC   = 6;
  localparam int POS_RXNE = 5;
  localparam int POS_IDLE = 4;
  localparam int POS_ORE  = 3;
  localparam int STAT_MIN_W = POS_TXE + 1;

  typedef struct packed {
    logic stat_rd;
    logic stat_wr;
    logic data_rd;
    logic data_wr;
  } bus_op_t;

  typedef struct packed {
    logic txe;
    logic tc;
    logic rxne;
    logic idle;
    logic ore;
  } flag_set_t;
endpackage

// File: rtl/uart_seq_tracker.sv
module uart_seq_tracker
  import uart_flag_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bus_op_t op,
  output logic    seq_mark
);
  logic breaks_seq;
  assign breaks_seq = op.stat_wr | op.data_rd | op.data_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seq_mark <= 1'b0;
    else if (op.stat_rd) seq_mark <= 1'b1;
    else if (breaks_seq) seq_mark <= 1'b0;
  end
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              stat_wr,
  input  logic              wbit_tc,
  input  logic              seq_mark,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_load,
  input  logic              frame_done,
  output logic              txe,
  output logic              tc,
  output logic [DATA_W-1:0] hold
);
  logic tc_set, tc_clr, txe_nxt, tc_nxt;

  assign tc_set = frame_done & txe;
  assign tc_clr = (data_wr & seq_mark) | (stat_wr & ~wbit_tc);

  always_comb begin
    txe_nxt = txe;
    if (data_wr) txe_nxt = 1'b0;
    if (tx_load) txe_nxt = 1'b1;
    tc_nxt = tc;
    if (tc_clr) tc_nxt = 1'b0;
    if (tc_set) tc_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe  <= 1'b1;
      tc   <= 1'b1;
      hold <= '0;
    end else begin
      txe <= txe_nxt;
      tc  <= tc_nxt;
      if (data_wr) hold <= wdata;
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_rd,
  input  logic              stat_wr,
  input  logic              wbit_rxne,
  input  logic              seq_mark,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              idle_det,
  output logic              rxne,
  output logic              idle,
  output logic              ore,
  output logic [DATA_W-1:0] rx_buf
);
  logic armed;
  logic word_load, word_lost, idle_set, seq_clr, rxne_clr;
  logic rxne_nxt, idle_nxt, ore_nxt, armed_nxt;

  assign word_load = rx_valid & (~rxne | data_rd);
  assign word_lost = rx_valid & rxne & ~data_rd;
  assign idle_set  = idle_det & armed;
  assign seq_clr   = data_rd & seq_mark;
  assign rxne_clr  = data_rd | (stat_wr & ~wbit_rxne);

  always_comb begin
    rxne_nxt = rxne;
    if (rxne_clr)  rxne_nxt = 1'b0;
    if (word_load) rxne_nxt = 1'b1;

    ore_nxt = ore;
    if (seq_clr)   ore_nxt = 1'b0;
    if (word_lost) ore_nxt = 1'b1;

    idle_nxt = idle;
    if (seq_clr)  idle_nxt = 1'b0;
    if (idle_set) idle_nxt = 1'b1;

    armed_nxt = armed;
    if (idle_set)  armed_nxt = 1'b0;
    if (word_load) armed_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxne   <= 1'b0;
      idle   <= 1'b0;
      ore    <= 1'b0;
      armed  <= 1'b0;
      rx_buf <= '0;
    end else begin
      rxne  <= rxne_nxt;
      idle  <= idle_nxt;
      ore   <= ore_nxt;
      armed <= armed_nxt;
      if (word_load) rx_buf <= rx_word;
    end
  end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_set_t flags,
  input  logic      ie_txe,
  input  logic      ie_tc,
  input  logic      ie_rxne,
  input  logic      ie_idle,
  input  logic      ie_err,
  input  logic      multibuf,
  output logic      irq
);
  localparam int N_SRC = 5;
  logic [N_SRC-1:0] src;

  assign src[0] = flags.txe & ie_txe;
  assign src[1] = flags.tc & ie_tc;
  assign src[2] = (flags.rxne | flags.ore) & ie_rxne;
  assign src[3] = flags.idle & ie_idle;
  assign src[4] = flags.ore & ie_err & multibuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |src;
  end
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tx_load,
  input  logic              tx_frame_done,
  output logic [DATA_W-1:0] tx_hold_data,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              idle_det,
  input  logic              ie_txe,
  input  logic              ie_tc,
  input  logic              ie_rxne,
  input  logic              ie_idle,
  input  logic              ie_err,
  input  logic              multibuf,
  output logic              irq
);
  localparam int STAT_PAD = DATA_W - STAT_MIN_W;

  bus_op_t           op;
  flag_set_t         flags;
  logic              seq_mark;
  logic              txe, tc, rxne, idle, ore;
  logic [DATA_W-1:0] rx_buf;
  logic [DATA_W-1:0] stat_word;

  assign op.stat_rd = rd_en & ~reg_sel;
  assign op.stat_wr = wr_en & ~reg_sel;
  assign op.data_rd = rd_en &  reg_sel;
  assign op.data_wr = wr_en &  reg_sel;

  uart_seq_tracker u_seq (
    .clk(clk), .rst_n(rst_n), .op(op), .seq_mark(seq_mark)
  );

  uart_tx_flags #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .data_wr(op.data_wr), .stat_wr(op.stat_wr), .wbit_tc(wr_data[POS_TC]),
    .seq_mark(seq_mark), .wdata(wr_data),
    .tx_load(tx_load), .frame_done(tx_frame_done),
    .txe(txe), .tc(tc), .hold(tx_hold_data)
  );

  uart_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .data_rd(op.data_rd), .stat_wr(op.stat_wr), .wbit_rxne(wr_data[POS_RXNE]),
    .seq_mark(seq_mark), .rx_valid(rx_valid), .rx_word(rx_word),
    .idle_det(idle_det),
    .rxne(rxne), .idle(idle), .ore(ore), .rx_buf(rx_buf)
  );

  assign flags = '{txe: txe, tc: tc, rxne: rxne, idle: idle, ore: ore};

  uart_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .flags(flags),
    .ie_txe(ie_txe), .ie_tc(ie_tc), .ie_rxne(ie_rxne), .ie_idle(ie_idle),
    .ie_err(ie_err), .multibuf(multibuf), .irq(irq)
  );

  generate
    if (STAT_PAD > 0) begin : g_pad
      assign stat_word[DATA_W-1:STAT_MIN_W] = '0;
    end
  endgenerate

  assign stat_word[POS_TXE]  = txe;
  assign stat_word[POS_TC]   = tc;
  assign stat_word[POS_RXNE] = rxne;
  assign stat_word[POS_IDLE] = idle;
  assign stat_word[POS_ORE]  = ore;
  assign stat_word[POS_ORE-1:0] = '0;

  assign rd_data = reg_sel ? rx_buf : stat_word;
endmodule

// File: rtl/uart_flag_ctrl_chk.sv
module uart_flag_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              rd_en,
  input logic              wr_en,
  input logic              tx_load,
  input logic              tx_frame_done,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_word,
  input logic              idle_det,
  input logic              ie_txe,
  input logic              txe,
  input logic              tc,
  input logic              rxne,
  input logic              idle,
  input logic              ore,
  input logic              seq_mark,
  input logic [DATA_W-1:0] rx_buf,
  input logic              irq
);
  assert_txe_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> txe);

  assert_txe_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && !tx_load) |=> !txe);

  assert_tc_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc && !(tx_frame_done && txe)) |=> !tc);

  assert_rx_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rxne) |=> (rxne && rx_buf == $past(rx_word)));

  assert_ovr_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rxne && !(rd_en && reg_sel)) |=> (ore && $stable(rx_buf)));

  assert_seq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel && seq_mark && !idle_det) |=> (!ore && !idle));

  assert_irq_txe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (txe && ie_txe) |=> irq);

  assert_rd_rx_same_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel && rx_valid && rxne && !ore) |=> (rxne && !ore));
endmodule

bind uart_flag_ctrl uart_flag_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
  .tx_load(tx_load), .tx_frame_done(tx_frame_done), .rx_valid(rx_valid),
  .rx_word(rx_word), .idle_det(idle_det), .ie_txe(ie_txe),
  .txe(txe), .tc(tc), .rxne(rxne), .idle(idle), .ore(ore),
  .seq_mark(seq_mark), .rx_buf(rx_buf), .irq(irq)
);

// File: tb/tb_uart_flag_ctrl.sv
`timescale 1ns/1ps
module tb_uart_flag_ctrl;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0, rx_word = '0;
  logic tx_load = 1'b0, tx_frame_done = 1'b0, rx_valid = 1'b0, idle_det = 1'b0;
  logic ie_txe = 1'b0, ie_tc = 1'b0, ie_rxne = 1'b0, ie_idle = 1'b0;
  logic ie_err = 1'b0, multibuf = 1'b0;
  logic [DW-1:0] rd_data, tx_hold_data;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // behavioural model state
  bit m_txe, m_tc, m_rxne, m_idle, m_ore, m_arm, m_mark, m_irq;
  logic [DW-1:0] m_buf, m_hold;

  always #2.5 clk = ~clk;

  uart_flag_ctrl #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tx_load(tx_load),
    .tx_frame_done(tx_frame_done), .tx_hold_data(tx_hold_data),
    .rx_valid(rx_valid), .rx_word(rx_word), .idle_det(idle_det),
    .ie_txe(ie_txe), .ie_tc(ie_tc), .ie_rxne(ie_rxne), .ie_idle(ie_idle),
    .ie_err(ie_err), .multibuf(multibuf), .irq(irq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] m_stat();
    logic [DW-1:0] s;
    s = '0;
    s[7] = m_txe; s[6] = m_tc; s[5] = m_rxne; s[4] = m_idle; s[3] = m_ore;
    return s;
  endfunction

  // reference model: advanced once per clock
  always @(posedge clk) begin
    bit sr, sw, dr, dw, load, lost;
    bit n_txe, n_tc, n_rxne, n_idle, n_ore, n_arm, n_mark, n_irq;
    if (!rst_n) begin
      m_txe = 1; m_tc = 1; m_rxne = 0; m_idle = 0; m_ore = 0;
      m_arm = 0; m_mark = 0; m_irq = 0; m_buf = '0; m_hold = '0;
    end else begin
      sr = rd_en && !reg_sel; sw = wr_en && !reg_sel;
      dr = rd_en && reg_sel;  dw = wr_en && reg_sel;
      n_irq = (m_txe && ie_txe) || (m_tc && ie_tc) || ((m_rxne || m_ore) && ie_rxne)
              || (m_idle && ie_idle) || (m_ore && ie_err && multibuf);
      n_txe = dw ? 0 : m_txe;
      if (tx_load) n_txe = 1;
      n_tc = ((dw && m_mark) || (sw && !wr_data[6])) ? 0 : m_tc;
      if (tx_frame_done && m_txe) n_tc = 1;
      load = rx_valid && (!m_rxne || dr);
      lost = rx_valid && m_rxne && !dr;
      n_rxne = (dr || (sw && !wr_data[5])) ? 0 : m_rxne;
      if (load) n_rxne = 1;
      n_ore = (dr && m_mark) ? 0 : m_ore;
      if (lost) n_ore = 1;
      n_idle = (dr && m_mark) ? 0 : m_idle;
      n_arm = m_arm;
      if (idle_det && m_arm) begin n_idle = 1; n_arm = 0; end
      if (load) begin n_arm = 1; m_buf = rx_word; end
      if (dw) m_hold = wr_data;
      n_mark = sr ? 1 : ((sw || dr || dw) ? 0 : m_mark);
      m_txe = n_txe; m_tc = n_tc; m_rxne = n_rxne; m_idle = n_idle; m_ore = n_ore;
      m_arm = n_arm; m_mark = n_mark; m_irq = n_irq;
    end
    #1;
    if (rst_n && cmp_on) begin
      chk("R2 rd_data vs model", rd_data, reg_sel ? m_buf : m_stat());
      chk("R11 irq vs model", {7'b0, irq}, {7'b0, m_irq});
      chk("R3 tx_hold_data vs model", tx_hold_data, m_hold);
    end
  end

  task automatic cyc(input logic s, r, w, input logic [DW-1:0] wd,
                     input logic txl, fd, rv, input logic [DW-1:0] rw, input logic idl);
    @(negedge clk);
    reg_sel = s; rd_en = r; wr_en = w; wr_data = wd;
    tx_load = txl; tx_frame_done = fd; rx_valid = rv; rx_word = rw; idle_det = idl;
    @(posedge clk);
    #2;
    rd_en = 0; wr_en = 0; tx_load = 0; tx_frame_done = 0; rx_valid = 0; idle_det = 0;
    reg_sel = 0; wr_data = '0;
  endtask

  task automatic nop();                             cyc(0,0,0,8'h00,0,0,0,8'h00,0); endtask
  task automatic stat_rd();                         cyc(0,1,0,8'h00,0,0,0,8'h00,0); endtask
  task automatic stat_wr(input logic [DW-1:0] d);   cyc(0,0,1,d,0,0,0,8'h00,0); endtask
  task automatic data_rd();                         cyc(1,1,0,8'h00,0,0,0,8'h00,0); endtask
  task automatic data_wr(input logic [DW-1:0] d);   cyc(1,0,1,d,0,0,0,8'h00,0); endtask
  task automatic rx(input logic [DW-1:0] w);        cyc(0,0,0,8'h00,0,0,1,w,0); endtask
  task automatic txl();                             cyc(0,0,0,8'h00,1,0,0,8'h00,0); endtask
  task automatic fdone();                           cyc(0,0,0,8'h00,0,1,0,8'h00,0); endtask
  task automatic idl();                             cyc(0,0,0,8'h00,0,0,0,8'h00,1); endtask

  task automatic peek_stat(input logic [DW-1:0] exp, input string tag);
    @(negedge clk); reg_sel = 0; #1; chk(tag, rd_data, exp);
  endtask
  task automatic peek_data(input logic [DW-1:0] exp, input string tag);
    @(negedge clk); reg_sel = 1; #1; chk(tag, rd_data, exp); reg_sel = 0;
  endtask
  task automatic peek_irq(input logic exp, input string tag);
    @(negedge clk); #1; chk(tag, {7'b0, irq}, {7'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    // R1 reset state
    peek_stat(8'hC0, "R1 reset status");
    peek_irq(1'b0, "R1 reset irq");
    peek_data(8'h00, "R2 data reg after reset");
    idl();
    peek_stat(8'hC0, "R1 idle disarmed after reset");
    // R3
    data_wr(8'h5A);
    peek_stat(8'h40, "R3 data write clears txe, tc kept (no status read)");
    chk("R3 hold data", tx_hold_data, 8'h5A);
    txl();
    peek_stat(8'hC0, "R3 tx_load sets txe");
    // R4 / R5 direct write
    stat_wr(8'h00);
    peek_stat(8'h80, "R5 write 0 clears tc");
    data_wr(8'hA1);
    fdone();
    peek_stat(8'h00, "R4 frame done ignored while txe=0");
    txl(); fdone();
    peek_stat(8'hC0, "R4 frame done with txe=1 sets tc");
    // R5 sequence and broken sequence
    stat_rd(); data_wr(8'hB2);
    peek_stat(8'h00, "R5 status read then data write clears tc");
    txl(); fdone();
    stat_rd(); stat_wr(8'hFF); data_wr(8'hC3);
    peek_stat(8'h40, "R5 broken sequence and write-1 keep tc");
    txl();
    // R6
    rx(8'h11);
    peek_stat(8'hE0, "R6 receive sets rxne");
    peek_data(8'h11, "R6 buffer holds word");
    data_rd();
    peek_stat(8'hC0, "R6 data read clears rxne");
    rx(8'h22); stat_wr(8'hDF);
    peek_stat(8'hC0, "R6 write 0 to bit5 clears rxne");
    // R7
    rx(8'h33); rx(8'h44);
    peek_stat(8'hE8, "R7 overrun set");
    peek_data(8'h33, "R7 buffer keeps old word");
    // R8
    stat_rd(); stat_wr(8'hFF); data_rd();
    peek_stat(8'hC8, "R8 broken sequence keeps ore");
    stat_rd(); data_rd();
    peek_stat(8'hC0, "R8 sequence clears ore");
    // R9
    idl();
    peek_stat(8'hD0, "R9 idle sets when armed");
    stat_rd(); data_rd();
    peek_stat(8'hC0, "R8 sequence clears idle");
    idl();
    peek_stat(8'hC0, "R9 idle not re-set before new word");
    rx(8'h55); idl();
    peek_stat(8'hF0, "R9 new word re-arms idle");
    stat_rd(); data_rd();
    peek_stat(8'hC0, "R8 clears rxne and idle");
    // R10 set beats clear
    rx(8'h66); stat_wr(8'hA0);
    peek_stat(8'hA0, "R5 tc cleared before R10");
    stat_rd();
    cyc(1,0,1,8'h01,0,1,0,8'h00,0);
    peek_stat(8'h60, "R10 tc set wins over sequence clear");
    cyc(1,0,1,8'h02,1,0,0,8'h00,0);
    peek_stat(8'hE0, "R10 txe set wins over data write");
    stat_rd();
    cyc(1,1,0,8'h00,0,0,0,8'h00,1);
    peek_stat(8'hD0, "R10 idle set wins over sequence clear");
    stat_rd(); data_rd();
    peek_stat(8'hC0, "R8 cleanup");
    // R12
    rx(8'h77);
    cyc(1,1,0,8'h00,0,0,1,8'h88,0);
    peek_stat(8'hE0, "R12 read with receive keeps rxne, no ore");
    peek_data(8'h88, "R12 new word stored");
    data_rd();
    // R11
    ie_txe = 1; nop();
    peek_irq(1'b1, "R11 txe enable raises irq");
    ie_txe = 0; nop();
    peek_irq(1'b0, "R11 no enables no irq");
    rx(8'h10); rx(8'h20);
    ie_err = 1; nop();
    peek_irq(1'b0, "R11 err enable needs multibuf");
    multibuf = 1; nop();
    peek_irq(1'b1, "R11 overrun with err enable in multibuf");
    ie_err = 0; multibuf = 0; ie_rxne = 1; nop();
    peek_irq(1'b1, "R11 rxne enable");
    ie_rxne = 0;
    stat_rd(); data_rd(); nop();
    peek_stat(8'hC0, "R8 cleanup 2");
    peek_irq(1'b0, "R11 irq low when disabled");
    // random phase, judged by the model each clock
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [DW-1:0] d;
      op = $urandom_range(0, 5);
      d = DW'($urandom);
      if (i % 50 == 0) begin
        {ie_txe, ie_tc, ie_rxne, ie_idle, ie_err, multibuf} = 6'($urandom);
      end
      cyc((op == 3 || op == 4) ? 1'b1 : 1'b0,
          (op == 1 || op == 3) ? 1'b1 : 1'b0,
          (op == 2 || op == 4) ? 1'b1 : 1'b0,
          d,
          ($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0,
          ($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0,
          ($urandom_range(0, 2) == 0) ? 1'b1 : 1'b0,
          DW'($urandom),
          ($urandom_range(0, 4) == 0) ? 1'b1 : 1'b0);
    end
    nop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule